// File: doc/BRIEF.md
# Self-Sequencing Fuse Word Reader

This block reads one 32-bit word from a one-time-programmable fuse array without any software timing. Software writes a control register that holds an enable bit, a read-request bit and a 10-bit word index. If both bits are set in that write, the controller runs its own access sequence. The sequence has a setup phase, a strobe phase, a capture cycle and a completion cycle, and the length of each timed phase is set by a parameter. At the end the controller places the word in a data-out register and raises a completion flag in a status register. Software polls the flag and clears it by writing a 1 to it.

The array holds 128 bytes, or 32 words. The lower 96 bytes (24 words) form a protected region. When the `secure_shift` strap is high at the moment a read is accepted, the requested word index is moved past that region by adding 24. The array is a preloaded read-only store whose contents are computed from a seed parameter. A word index that falls outside the array returns zero.

Top module: `fuse_auto_reader`

## Requirements
- R1: After a synchronous reset, the completion flag is 0, the data-out register is 0 and the control register reads as 0.
- R2: A write to offset 0x24 in the idle state stores bit 0 (enable), bit 1 (read request) and bits [25:16] (word index). These fields read back at the same positions. A read starts only if bits 0 and 1 are both 1 in that write.
- R3: With the default timing (3 setup cycles and 4 strobe cycles), the completion flag rises exactly 9 clock edges after the edge that accepts the start write. Data-out changes one edge earlier.
- R4: Word index w returns bytes 4w to 4w+3 in little-endian order, with byte 4w in bits [7:0]. Byte k has the value (7k + 0x3C) mod 256. Any index of 32 or more returns 0.
- R5: Bit 0 of offset 0x18 is the completion flag. A write to 0x18 with bit 0 equal to 1 clears it, and a write with bit 0 equal to 0 has no effect. If a completion and a clear fall in the same cycle, the flag ends up set.
- R6: The read-request bit clears itself when the read completes. The enable bit is kept.
- R7: A write to offset 0x24 made while a read is in progress is ignored completely. It starts no read and changes no field.
- R8: Data-out, readable at offset 0x20, keeps the last completed word until the next read completes.
- R9: When `secure_shift` is high at the accepting edge, the word index used for the read is the stored index plus 24.
- R10: rdata holds the value of the addressed register one edge after `rd_en`. Offsets other than 0x18, 0x20 and 0x24 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secure_shift | input | 1 | Strap that moves the word index past the protected region |
| bus_addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 32 | Registered read data |
| dout_o | output | 32 | Current content of the data-out register |
| done_o | output | 1 | Current value of the completion flag |

## Verification
Assertions check on every cycle the following properties:
- The flag can rise only in the cycle after the sequencer's completion state.
- The read-request bit is clear after completion.
- Data-out is stable whenever the sequencer is not in its capture state.
- The word index is unchanged after a control write made while the controller is busy.
- The sequencer's phase counter stays within its bound.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared with the outputs on every clock:
- the exact latency;
- the computed array contents;
- the effect of the offset strap;
- out-of-range indices returning zero;
- clear writes whose bit 0 is 0;
- a completion and a clear falling in the same cycle.

// File: rtl/fuse_auto_pkg.sv
package fuse_auto_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE,
    SQ_CAPTURE,
    SQ_DONE
  } seq_state_e;

  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_DOUT   = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h24;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RD_BIT   = 1;
  localparam int CTRL_IDX_LSB  = 16;
endpackage

// File: rtl/fuse_word_rom.sv
module fuse_word_rom #(
  parameter int WORDS = 32,
  parameter int IDX_IN_W = 11,
  parameter logic [7:0] SEED = 8'h3C
) (
  input  logic                clk,
  input  logic [IDX_IN_W-1:0] idx,
  output logic [31:0]         q
);
  localparam int IDX_W = $clog2(WORDS);

  logic [31:0] mem [WORDS];
  logic [31:0] mem_q;
  logic        oor_q;

  initial begin
    for (int w = 0; w < WORDS; w++) begin
      for (int b = 0; b < 4; b++) begin
        mem[w][8*b +: 8] = 8'(((4*w + b) * 7) + int'(SEED));
      end
    end
  end

  // Registered read for block RAM inference; range flag kept alongside.
  always_ff @(posedge clk) begin
    mem_q <= mem[idx[IDX_W-1:0]];
    oor_q <= (idx >= IDX_IN_W'(WORDS));
  end

  assign q = oor_q ? 32'h0 : mem_q;
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_auto_pkg::*;
#(
  parameter int SETUP_CYC  = 3,
  parameter int STROBE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic cap_o,
  output logic done_o
);
  localparam int MAXC  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= SQ_SETUP;
        end
        SQ_SETUP: begin
          if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= SQ_STROBE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_STROBE: begin
          if (cnt_q == CNT_W'(STROBE_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= SQ_CAPTURE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_CAPTURE: state_q <= SQ_DONE;
        SQ_DONE:    state_q <= SQ_IDLE;
        default:    state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SQ_IDLE);
  assign cap_o  = (state_q == SQ_CAPTURE);
  assign done_o = (state_q == SQ_DONE);

  // R3
  setup_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SETUP) |-> (cnt_q < CNT_W'(SETUP_CYC)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_DONE) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/fuse_auto_reader.sv
module fuse_auto_reader
  import fuse_auto_pkg::*;
#(
  parameter int         WORDS      = 32,
  parameter int         SEC_WORDS  = 24,
  parameter int         IDX_W      = 10,
  parameter int         SETUP_CYC  = 3,
  parameter int         STROBE_CYC = 4,
  parameter logic [7:0] SEED       = 8'h3C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        secure_shift,
  input  logic [7:0]  bus_addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  output logic [31:0] dout_o,
  output logic        done_o
);
  localparam int EFF_W = IDX_W + 1;
  localparam logic [EFF_W-1:0] SEC_OFS = EFF_W'(SEC_WORDS);

  logic             ctrl_en_q, ctrl_rd_q, shift_q, flag_q;
  logic [IDX_W-1:0] ctrl_idx_q;
  logic [31:0]      dout_q, rdata_q, rom_q;
  logic [EFF_W-1:0] eff_idx;
  logic             seq_busy, seq_cap, seq_done;
  logic             wr_ctrl, accept, start, clr_req;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:CTRL_IDX_LSB+IDX_W], wdata[CTRL_IDX_LSB-1:2]};

  assign wr_ctrl = wr_en && (bus_addr == OFS_CTRL);
  assign accept  = wr_ctrl && !seq_busy;
  assign start   = accept && wdata[CTRL_EN_BIT] && wdata[CTRL_RD_BIT];
  assign clr_req = wr_en && (bus_addr == OFS_STATUS) && wdata[0];
  assign eff_idx = {1'b0, ctrl_idx_q} + (shift_q ? SEC_OFS : '0);

  fuse_read_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .busy_o (seq_busy),
    .cap_o  (seq_cap),
    .done_o (seq_done)
  );

  fuse_word_rom #(
    .WORDS   (WORDS),
    .IDX_IN_W(EFF_W),
    .SEED    (SEED)
  ) u_rom (
    .clk(clk),
    .idx(eff_idx),
    .q  (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q  <= 1'b0;
      ctrl_rd_q  <= 1'b0;
      ctrl_idx_q <= '0;
      shift_q    <= 1'b0;
    end else if (accept) begin
      ctrl_en_q  <= wdata[CTRL_EN_BIT];
      ctrl_rd_q  <= wdata[CTRL_RD_BIT];
      ctrl_idx_q <= wdata[CTRL_IDX_LSB +: IDX_W];
      shift_q    <= secure_shift;
    end else if (seq_done) begin
      ctrl_rd_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (seq_cap) dout_q <= rom_q;
      if (seq_done)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        OFS_STATUS: rdata_q <= {31'b0, flag_q};
        OFS_DOUT:   rdata_q <= dout_q;
        OFS_CTRL: begin
          rdata_q <= '0;
          rdata_q[CTRL_IDX_LSB +: IDX_W] <= ctrl_idx_q;
          rdata_q[CTRL_RD_BIT] <= ctrl_rd_q;
          rdata_q[CTRL_EN_BIT] <= ctrl_en_q;
        end
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata  = rdata_q;
  assign dout_o = dout_q;
  assign done_o = flag_q;

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(seq_done));

  // R6
  rd_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !ctrl_rd_q);

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_cap |=> $stable(dout_q));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && seq_busy) |=> $stable(ctrl_idx_q));
endmodule

// File: tb/fuse_auto_reader_tb.sv
module fuse_auto_reader_tb;
  localparam int WORDS = 32;
  localparam int SEC   = 24;
  localparam int LAT   = 3 + 4 + 2;
  localparam int SEED  = 'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        secure_shift = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata, dout_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  fuse_auto_reader u_dut (
    .clk(clk), .rst(rst), .secure_shift(secure_shift),
    .bus_addr(bus_addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .dout_o(dout_o), .done_o(done_o)
  );

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] v = '0;
    if (w >= WORDS) return 32'h0;
    for (int b = 0; b < 4; b++) v[8*b +: 8] = 8'((4*w + b) * 7 + SEED);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_en, m_rd, m_shift, m_flag;
  int          m_idx, m_cnt;
  logic [31:0] m_dout, m_rdata, m_word;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_rd = 0; m_shift = 0; m_flag = 0; m_idx = 0; m_cnt = 0;
      m_dout = '0; m_rdata = '0; m_word = '0;
    end else begin
      bit busy;
      bit set;
      busy = (m_cnt > 0);
      set = 0;
      if (rd_en) begin
        if (bus_addr == 8'h18)      m_rdata = {31'b0, m_flag};
        else if (bus_addr == 8'h20) m_rdata = m_dout;
        else if (bus_addr == 8'h24) m_rdata = (32'(m_idx) << 16) | {30'b0, m_rd, m_en};
        else                        m_rdata = '0;
      end
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 1) m_dout = m_word;
        if (m_cnt == 0) begin set = 1; m_rd = 0; end
      end
      if (set) m_flag = 1;
      else if (wr_en && bus_addr == 8'h18 && wdata[0]) m_flag = 0;
      if (wr_en && bus_addr == 8'h24 && !busy) begin
        m_en = wdata[0]; m_rd = wdata[1]; m_idx = int'(wdata[25:16]); m_shift = secure_shift;
        if (wdata[0] && wdata[1]) begin
          m_cnt = LAT;
          m_word = exp_word(m_idx + (m_shift ? SEC : 0));
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !ended) begin
      check(done_o == m_flag, "R5 flag vs model", {31'b0, done_o}, {31'b0, m_flag});
      check(dout_o == m_dout, "R8 dout vs model", dout_o, m_dout);
      check(rdata == m_rdata, "R10 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; bus_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a);
    rd_en = 1; bus_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done_o && k < 100) begin @(negedge clk); k++; end
  endtask

  function automatic logic [31:0] ctrl_word(int idx, bit r, bit e);
    return (32'(idx) << 16) | {30'b0, r, e};
  endfunction

  initial begin
    int k;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(done_o == 0, "R1 flag after reset", {31'b0, done_o}, 0);
    check(dout_o == 0, "R1 dout after reset", dout_o, 0);
    rd(8'h24);
    check(rdata == 0, "R1 ctrl after reset", rdata, 0);

    // R2: enable alone does not start
    wr(8'h24, ctrl_word(3, 0, 1));
    repeat (15) @(negedge clk);
    check(done_o == 0, "R2 no start without read bit", {31'b0, done_o}, 0);
    rd(8'h24);
    check(rdata == ctrl_word(3, 0, 1), "R2 ctrl readback", rdata, ctrl_word(3, 0, 1));

    // R3, R4, R6
    wr(8'h24, ctrl_word(3, 1, 1));
    wait_done(k);
    check(k == LAT, "R3 latency", 32'(k), 32'(LAT));
    check(dout_o == exp_word(3), "R4 word 3", dout_o, exp_word(3));
    rd(8'h24);
    check(rdata == ctrl_word(3, 0, 1), "R6 read bit self-clears", rdata, ctrl_word(3, 0, 1));

    // R5: clear behaviour
    wr(8'h18, 32'h0);
    check(done_o == 1, "R5 zero write keeps flag", {31'b0, done_o}, 1);
    wr(8'h18, 32'h1);
    check(done_o == 0, "R5 write-one clears", {31'b0, done_o}, 0);

    // R9: protected-region shift
    secure_shift = 1;
    wr(8'h24, ctrl_word(2, 1, 1));
    secure_shift = 0;
    wait_done(k);
    check(dout_o == exp_word(26), "R9 shifted word", dout_o, exp_word(26));
    wr(8'h18, 32'h1);

    // R7: write during busy ignored
    wr(8'h24, ctrl_word(5, 1, 1));
    wr(8'h24, ctrl_word(9, 1, 1));
    wait_done(k);
    check(dout_o == exp_word(5), "R7 busy write ignored", dout_o, exp_word(5));
    rd(8'h24);
    check(rdata[25:16] == 10'd5, "R7 index unchanged", {22'b0, rdata[25:16]}, 32'd5);
    repeat (LAT + 3) @(negedge clk);
    check(dout_o == exp_word(5), "R7 no second read", dout_o, exp_word(5));
    wr(8'h18, 32'h1);

    // R4: out of range
    secure_shift = 1;
    wr(8'h24, ctrl_word(8, 1, 1));
    secure_shift = 0;
    wait_done(k);
    check(dout_o == 0, "R4 shifted index out of range", dout_o, 0);
    wr(8'h18, 32'h1);
    wr(8'h24, ctrl_word(31, 1, 1));
    wait_done(k);
    check(dout_o == exp_word(31), "R4 last word", dout_o, exp_word(31));
    wr(8'h18, 32'h1);
    wr(8'h24, ctrl_word(1023, 1, 1));
    wait_done(k);
    check(dout_o == 0, "R4 max index reads zero", dout_o, 0);
    wr(8'h18, 32'h1);

    // R8: hold
    wr(8'h24, ctrl_word(0, 1, 1));
    wait_done(k);
    held = dout_o;
    check(held == exp_word(0), "R4 word 0", held, exp_word(0));
    wr(8'h24, ctrl_word(7, 0, 1));
    repeat (20) @(negedge clk);
    check(dout_o == held, "R8 dout holds", dout_o, held);
    rd(8'h20);
    check(rdata == held, "R8 dout via bus", rdata, held);
    wr(8'h18, 32'h1);

    // R5: completion and clear in the same cycle
    wr(8'h24, ctrl_word(1, 1, 1));
    repeat (LAT - 1) @(negedge clk);
    wr(8'h18, 32'h1);
    check(done_o == 1, "R5 set wins over clear", {31'b0, done_o}, 1);
    rd(8'h18);
    check(rdata == 1, "R5 status via bus", rdata, 1);

    // R10: unmapped offset
    rd(8'h04);
    check(rdata == 0, "R10 unmapped offset", rdata, 0);

    repeat (3) @(negedge clk);
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule